// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block guards a processor against runaway software. A prescaler divides the system clock by 2^(p+3), where p is a 3-bit select, so the divide runs from 8 to 1024. Each prescaler tick advances a free-running main counter that is `CNT_W` bits wide (16 by default). Software starts counting by setting the enable bit in the control register. It must refresh the counter with the clear bit before the counter wraps. If the counter does wrap, the block drives a one-cycle reset pulse, clears its own control state and raises a sticky cause flag. The flag lets software tell, after the restart, that the watchdog caused the reset.

Control is a small state machine with three states. In ST_OFF nothing advances. In ST_RUN both counters advance. ST_FIRE is the single cycle in which the reset pulse is driven. The transitions are:
- ST_OFF to ST_RUN on a control write with enable = 1.
- ST_RUN to ST_OFF on a control write with enable = 0.
- ST_RUN to ST_FIRE on a counter wrap that no refresh or disable write overrides.
- ST_FIRE to ST_OFF unconditionally.
- Any state to ST_OFF on power-on or external reset.

Register access has one write port and one combinational read port. Select 0 addresses the control register and select 1 addresses the status register. Both reset inputs are synchronous and active high.

Top module: `wdog_timer`

## Requirements
- R1: While power-on or external reset is applied, and after it is released, both registers read 0x00 and the reset output is low.
- R2: Control register layout (select 0): bit 7 is enable, bit 5 is clear and bits 2:0 are the prescale select p. Clear and the unused bits 6, 4 and 3 always read 0. Status register (select 1): bit 0 is the cause flag and bits 7:1 read 0.
- R3: Take the edge on which a write sets enable with select p. With T = 2^CNT_W · 2^(p+3), the reset output is high for exactly the one cycle that follows the T-th rising edge after that write edge.
- R4: While enable is 0, neither counter advances. Enabled time accumulates across a disable and a later re-enable.
- R5: A control write with clear = 1 zeroes both counters at that edge, so a full period T restarts from it. The other fields of the same write also take effect.
- R6: On a timeout, the control register returns to 0x00 (disabled, p = 0) and the status flag reads 1 in the same cycle as the reset pulse. No further pulse follows.
- R7: The cause flag survives the watchdog's own reset. Writing 0 to status bit 0 clears it, and writing 1 leaves it unchanged. Power-on reset clears it, and so does external reset.
- R8: A control write with clear = 1 or enable = 0 on the edge where the counter would wrap suppresses the reset pulse.
- R9: A timeout and a status write of 0 on the same edge leave the flag at 1.
- R10: A control write with enable = 1 and clear = 0 while already running does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_i | input | 1 | External reset, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 status |
| rd_data_o | output | 8 | Combinational read data |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two pairs of functions can land on the same clock edge. A software refresh or disable can coincide with the counter wrap, and the wrap setting the cause flag can coincide with a software write of 0 to that flag. The bench counts cycles from the enabling write so that the refresh, disable or flag write strikes exactly the wrap edge. It then judges the reset output in the next cycle, reads back both registers, and for a refresh confirms that a fresh full period follows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_e;

    localparam int DATA_W      = 8;
    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_CLR_BIT = 5;
    localparam int FLAG_BIT    = 0;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PS_W     = 3,
    parameter int PRE_BASE = 3
) (
    input  logic            clk,
    input  logic            clr_i,
    input  logic            run_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);
    localparam int PRE_W = PRE_BASE + (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Low (p + PRE_BASE) bits all ones marks the end of one divided period.
    for (genvar g = 0; g < PRE_W; g++) begin : g_mask
        assign mask[g] = (int'(ps_i) + PRE_BASE) > g;
    end

    assign tick_o = run_i && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (clr_i) begin
            pre_q <= '0;
        end else if (run_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (clr_i)
        !run_i |=> $stable(pre_q)); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic clr_i,
    input  logic tick_i,
    output logic wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = tick_i && (&cnt_q);

    always_ff @(posedge clk) begin
        if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (clr_i)
        !tick_i |=> $stable(cnt_q)); // R4
    AST_CNT_WRAP_ZERO: assert property (@(posedge clk) disable iff (clr_i)
        wrap_o |=> cnt_q == '0); // R3
endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic              clk,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wrap_i,
    output logic              run_o,
    output logic [PS_W-1:0]   ps_o,
    output logic              flag_o,
    output logic              cnt_clr_o,
    output logic              fire_o
);
    wdt_state_e      state_q, state_d;
    logic [PS_W-1:0] ps_q;
    logic            flag_q;
    logic            fire_q;
    logic            ctl_wr, st_wr, guard, fire_take;

    assign ctl_wr    = wr_en_i && !wr_sel_i && (state_q != ST_FIRE);
    assign st_wr     = wr_en_i &&  wr_sel_i && (state_q != ST_FIRE);
    assign guard     = ctl_wr && (wr_data_i[CTL_CLR_BIT] || !wr_data_i[CTL_EN_BIT]);
    assign fire_take = (state_q == ST_RUN) && (state_d == ST_FIRE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctl_wr && wr_data_i[CTL_EN_BIT]) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctl_wr && !wr_data_i[CTL_EN_BIT]) state_d = ST_OFF;
                else if (wrap_i && !guard)            state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_i) state_q <= ST_OFF;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            ps_q   <= '0;
            flag_q <= 1'b0;
            fire_q <= 1'b0;
        end else if (fire_take) begin
            ps_q   <= '0;
            flag_q <= 1'b1;
            fire_q <= 1'b1;
        end else begin
            fire_q <= 1'b0;
            if (ctl_wr) ps_q <= wr_data_i[PS_W-1:0];
            if (st_wr && !wr_data_i[FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    assign run_o     = (state_q == ST_RUN);
    assign ps_o      = ps_q;
    assign flag_o    = flag_q;
    assign fire_o    = fire_q;
    assign cnt_clr_o = rst_i || (ctl_wr && wr_data_i[CTL_CLR_BIT]) || fire_take
                       || (state_q == ST_FIRE);

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst_i)
        fire_q |=> !fire_q); // R3
    AST_FIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst_i)
        fire_q |-> flag_q); // R6
    AST_FIRE_DISABLES: assert property (@(posedge clk) disable iff (rst_i)
        fire_q |=> (!run_o && ps_q == '0)); // R6
    AST_FLAG_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst_i)
        $fell(flag_q) |-> $past(rst_i || (st_wr && !wr_data_i[FLAG_BIT]))); // R7
    AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (rst_i)
        (run_o && wrap_i && guard) |=> !fire_q); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PS_W     = 3,
    parameter int PRE_BASE = 3
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              ext_rst_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wdt_rst_o
);
    logic            rst_any;
    logic            run, flag, cnt_clr, tick, wrap;
    logic [PS_W-1:0] ps;
    logic [DATA_W-1:0] ctl_view, st_view;

    assign rst_any = por_i || ext_rst_i;

    wdt_ctrl_fsm #(.PS_W(PS_W)) u_fsm (
        .clk       (clk),
        .rst_i     (rst_any),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .wrap_i    (wrap),
        .run_o     (run),
        .ps_o      (ps),
        .flag_o    (flag),
        .cnt_clr_o (cnt_clr),
        .fire_o    (wdt_rst_o)
    );

    wdt_prescaler #(.PS_W(PS_W), .PRE_BASE(PRE_BASE)) u_pre (
        .clk    (clk),
        .clr_i  (cnt_clr),
        .run_i  (run),
        .ps_i   (ps),
        .tick_o (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .clr_i  (cnt_clr),
        .tick_i (tick),
        .wrap_o (wrap)
    );

    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_EN_BIT] = run;
        ctl_view[PS_W-1:0]   = ps;
        st_view = '0;
        st_view[FLAG_BIT]    = flag;
    end

    assign rd_data_o = rd_sel_i ? st_view : ctl_view;

    AST_FIRE_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst_any)
        $rose(wdt_rst_o) |-> $past(wrap && run)); // R3
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst_any)
        !rd_sel_i |-> !rd_data_o[CTL_CLR_BIT]); // R2
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
    localparam int CW = 6;

    logic       clk = 1'b0;
    logic       por = 1'b1, ext = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wrst;
    int         nchk = 0, nfail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    wdog_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .por_i(por), .ext_rst_i(ext), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .wdt_rst_o(wrst)
    );

    function automatic int per(input int p);
        return (1 << CW) << (p + 3);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic cyc(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wrst) highs++;
        end
    endtask

    task automatic ext_pulse();
        ext = 1'b1; @(negedge clk); ext = 1'b0;
    endtask

    task automatic expect_fire(input string req, input int n);
        int h;
        cyc(n - 1, h);
        chk({req, " no early pulse"}, h, 0);
        @(negedge clk);
        chk({req, " pulse"}, int'(wrst), 1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rd(0, v); chk("R1 ctrl in por", v, 0);
        chk("R1 rst out", int'(wrst), 0);
        por = 1'b0; @(negedge clk);
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 status", v, 0);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        ext_pulse();
        wr(0, 8'h83); rd(0, v); chk("R2 en+ps3", v, 8'h83);
        wr(0, 8'hFF); rd(0, v); chk("R2 reserved/clear read 0", v, 8'h87);
        wr(0, 8'h25); rd(0, v); chk("R2 disable", v, 8'h05);
        rd(1, v); chk("R2 status", v, 0);
    endtask

    task automatic t_timeout(input int p, input int tail);
        logic [7:0] v;
        int h;
        ext_pulse();
        wr(0, 8'h80 | 8'(p));
        expect_fire($sformatf("R3 p=%0d", p), per(p));
        rd(0, v); chk("R6 ctrl cleared", v, 0);
        rd(1, v); chk("R6 flag set", v, 1);
        cyc(tail, h); chk("R6 no second pulse", h, 0);
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        int h;
        ext_pulse();
        wr(0, 8'h80);
        cyc(100, h);
        wr(0, 8'h00);
        cyc(3 * per(0), h); chk("R4 no pulse while off", h, 0);
        rd(1, v); chk("R4 flag while off", v, 0);
        wr(0, 8'h80);
        expect_fire("R4 resume", per(0) - 101);
    endtask

    task automatic t_clear();
        int h;
        ext_pulse();
        wr(0, 8'h80);
        cyc(300, h);
        wr(0, 8'hA1);
        cyc(per(0), h); chk("R5 no pulse at old time", h, 0);
        expect_fire("R5 full period p=1", per(1) - per(0));
    endtask

    task automatic t_rewrite();
        int h;
        ext_pulse();
        wr(0, 8'h80);
        cyc(200, h);
        wr(0, 8'h80);
        expect_fire("R10 no restart", per(0) - 201);
    endtask

    task automatic t_flag();
        logic [7:0] v;
        t_timeout(0, 4);
        wr(1, 8'h01); rd(1, v); chk("R7 write 1 keeps", v, 1);
        wr(1, 8'hFE); rd(1, v); chk("R7 write 0 clears", v, 0);
        t_timeout(0, 4);
        ext_pulse(); rd(1, v); chk("R7 ext clears", v, 0);
        t_timeout(0, 4);
        por = 1'b1; @(negedge clk); por = 1'b0;
        rd(1, v); chk("R7 por clears", v, 0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        int h;
        ext_pulse();
        wr(0, 8'h80);
        cyc(per(0) - 1, h);
        wr(0, 8'hA0);
        chk("R8 clear at wrap", int'(wrst), 0);
        rd(0, v); chk("R8 still running", v, 8'h80);
        expect_fire("R8 new period", per(0));
        ext_pulse();
        wr(0, 8'h80);
        cyc(per(0) - 1, h);
        wr(0, 8'h00);
        cyc(2 * per(0), h); chk("R8 disable at wrap", h, 0);
        rd(1, v); chk("R8 no flag", v, 0);
        // R9: flag set already, software clears on the wrap edge
        t_timeout(0, 2);
        wr(0, 8'h80);
        cyc(per(0) - 1, h);
        wr(1, 8'h00);
        chk("R9 pulse", int'(wrst), 1);
        rd(1, v); chk("R9 flag set wins", v, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_layout();
        t_timeout(0, 2 * per(0));
        t_timeout(2, 100);
        t_timeout(7, 100);
        t_freeze();
        t_clear();
        t_rewrite();
        t_flag();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule